// File: doc/BRIEF.md
# Two-Port Shared Word Store with Collision Arbitration

This block is a 256-word by 9-bit memory that two independent agents can reach at the same time. Each side, A and B, has its own address and its own active-low select, write-strobe and read-enable inputs. Each side also has a write-data bus, a registered read-data bus with a valid flag that stands in for an output driver, and an active-low stall flag. Two processors use it to pass messages. Each one treats its side as ordinary RAM.

The controls are sampled on every rising clock edge. A collision exists when both sides are selected on the same word. In that case the side that set up its part of the collision first keeps full access. The other side sees its stall flag go low, and any write from it is discarded for as long as the collision lasts. If both sides arrive in the same cycle, side A wins. The stall releases by itself as soon as the addresses differ or either side deselects. If the late side is still holding its write strobe at that point, its write completes on that edge.

Top module: `mbox_dual_ram`

## Requirements
- R1: The store holds 2^8 words of 9 bits, addressed by an 8-bit address per side; a word written from either side is read back unchanged from either side.
- R2: With select high (inactive), a side neither writes nor reads: the valid flag is 0 one cycle later and the addressed word keeps its value even if the write strobe is low.
- R3: Select low and write strobe low at a rising edge store the write data at that edge. Select low, write strobe high and read-enable low at an edge load that word into the read-data output with valid=1 after the edge. The word loaded is the one stored before that edge (read-first).
- R4: Read-enable high (with select low and write strobe high) gives valid=0 after the edge.
- R5: A collision is both selects low with equal addresses. A side that was selected on the same address in the previous cycle while the other side was not counts as first. The first side keeps its stall flag at 1 for the whole collision, and exactly one side is stalled.
- R6: During a collision the late side's stall flag is 0 whether it reads or writes, and its write is discarded.
- R7: When the collision ends (address change or deselect of either side), both stall flags are 1 in that cycle, and a write still held by the formerly late side is stored at that edge.
- R8: When a collision begins with neither side already in place, side A is given priority and side B is stalled.
- R9: During a collision both sides still read the correct stored word.
- R10: Synchronous active-high reset clears all read-valid flags and the arbitration history. A collision standing when reset is released is resolved as a same-cycle arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_cs_n | input | 1 | Side A select, active low |
| a_we_n | input | 1 | Side A write strobe, active low |
| a_oe_n | input | 1 | Side A read enable, active low |
| a_addr | input | 8 | Side A word address |
| a_wdata | input | 9 | Side A write data |
| a_rdata | output | 9 | Side A read data, registered |
| a_rvalid | output | 1 | Side A read data valid (driver-on model) |
| a_stall_n | output | 1 | Side A stall flag, active low |
| b_cs_n | input | 1 | Side B select, active low |
| b_we_n | input | 1 | Side B write strobe, active low |
| b_oe_n | input | 1 | Side B read enable, active low |
| b_addr | input | 8 | Side B word address |
| b_wdata | input | 9 | Side B write data |
| b_rdata | output | 9 | Side B read data, registered |
| b_rvalid | output | 1 | Side B read data valid (driver-on model) |
| b_stall_n | output | 1 | Side B stall flag, active low |

## Verification
The bench targets three collision orderings:
- A in place first and B arriving by select. A design that ignored arrival order would stall A or let B's write land.
- Both arriving together from idle. A design with no tie rule would stall both sides or neither; here B's write must be lost.
- B in place first and A arriving by address change. A design that always favoured A would stall B instead.

Release is checked by making the stalled write land on the cycle the collision clears. A design that latched the stall would lose that write. Reset is asserted in the middle of a collision; a design that kept the old owner would keep stalling A afterwards. A deselected write strobe must leave the stored word unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NSIDE = 2;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb
  import mbox_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NSIDE-1:0] sel,
  input  logic [AW-1:0] addr [NSIDE],
  output logic [NSIDE-1:0] stall_n,
  output logic [NSIDE-1:0] blocked
);
  logic [NSIDE-1:0] sel_q;
  logic [AW-1:0]    addr_q [NSIDE];
  logic [NSIDE-1:0] in_place;
  owner_e           own_q, own_d;
  logic             clash;

  assign clash = sel[0] & sel[1] & (addr[0] == addr[1]);

  for (genvar i = 0; i < NSIDE; i++) begin : g_hist
    assign in_place[i] = sel_q[i] && (addr_q[i] == addr[i]);
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]  <= 1'b0;
        addr_q[i] <= '0;
      end else begin
        sel_q[i]  <= sel[i];
        addr_q[i] <= addr[i];
      end
    end
  end

  always_comb begin
    if (own_q != OWN_NONE)               own_d = own_q;
    else if (in_place[1] && !in_place[0]) own_d = OWN_B;
    else                                  own_d = OWN_A;
  end

  assign stall_n[0] = !(clash && own_d == OWN_B);
  assign stall_n[1] = !(clash && own_d == OWN_A);
  assign blocked    = ~stall_n;

  always_ff @(posedge clk) begin
    if (rst) own_q <= OWN_NONE;
    else     own_q <= clash ? own_d : OWN_NONE;
  end

  // R5: exactly one side flagged while a collision stands
  p_single_flag_r5: assert property (@(posedge clk) disable iff (rst)
    clash |-> ($countones(stall_n) == 1));
  // R7: no stall without a collision
  p_flag_needs_clash_r7: assert property (@(posedge clk) disable iff (rst)
    !clash |-> (&stall_n));
  // R5: priority does not change hands while the collision persists
  p_owner_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (clash && $past(clash) && !$past(rst)) |-> (stall_n == $past(stall_n)));
endmodule

// File: rtl/mbox_mem.sv
module mbox_mem
  import mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NSIDE-1:0] wen,
  input  logic [AW-1:0] addr  [NSIDE],
  input  logic [DW-1:0] wdata [NSIDE],
  output logic [DW-1:0] rdata [NSIDE]
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wen[0]) store[addr[0]] <= wdata[0];
    if (wen[1]) store[addr[1]] <= wdata[1];
  end

  for (genvar i = 0; i < NSIDE; i++) begin : g_rd
    always_ff @(posedge clk) rdata[i] <= store[addr[i]];
  end

  // R6: two writes never target the same word in one cycle
  p_no_dual_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wen[0] && wen[1]) |-> (addr[0] != addr[1]));
endmodule

// File: rtl/mbox_side.sv
module mbox_side (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic blocked,
  output logic sel,
  output logic wen,
  output logic rvalid
);
  assign sel = !cs_n;
  assign wen = !cs_n && !we_n && !blocked;

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= !cs_n && we_n && !oe_n;
  end

  // R2: a deselected side never shows valid data
  p_off_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !rvalid);
  // R4: read enable high keeps the output off
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $past(oe_n) |-> !rvalid);
endmodule

// File: rtl/mbox_dual_ram.sv
module mbox_dual_ram
  import mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_cs_n,
  input  logic          a_we_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  output logic          a_stall_n,
  input  logic          b_cs_n,
  input  logic          b_we_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid,
  output logic          b_stall_n
);
  logic [NSIDE-1:0] cs_n, we_n, oe_n, sel, wen, rvalid, stall_n, blocked;
  logic [AW-1:0]    addr  [NSIDE];
  logic [DW-1:0]    wdata [NSIDE];
  logic [DW-1:0]    rdata [NSIDE];

  assign cs_n     = {b_cs_n, a_cs_n};
  assign we_n     = {b_we_n, a_we_n};
  assign oe_n     = {b_oe_n, a_oe_n};
  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    mbox_side u_side (
      .clk    (clk),
      .rst    (rst),
      .cs_n   (cs_n[i]),
      .we_n   (we_n[i]),
      .oe_n   (oe_n[i]),
      .blocked(blocked[i]),
      .sel    (sel[i]),
      .wen    (wen[i]),
      .rvalid (rvalid[i])
    );
  end

  mbox_arb #(.AW(AW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .addr   (addr),
    .stall_n(stall_n),
    .blocked(blocked)
  );

  mbox_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .wen  (wen),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata)
  );

  assign a_rdata   = rdata[0];
  assign b_rdata   = rdata[1];
  assign a_rvalid  = rvalid[0];
  assign b_rvalid  = rvalid[1];
  assign a_stall_n = stall_n[0];
  assign b_stall_n = stall_n[1];

  // R6: a stalled side never writes
  p_stalled_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!a_stall_n |-> !wen[0]) and (!b_stall_n |-> !wen[1]));
endmodule

// File: tb/sim_mbox_dual_ram.sv
module sim_mbox_dual_ram;
  logic clk = 1'b0;
  logic rst;
  logic a_cs_n, a_we_n, a_oe_n, b_cs_n, b_we_n, b_oe_n;
  logic [7:0] a_addr, b_addr;
  logic [8:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid, a_stall_n, b_stall_n;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mbox_dual_ram u0 (
    .clk(clk), .rst(rst),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_stall_n(a_stall_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_stall_n(b_stall_n)
  );

  // ctl = {cs_n, we_n, oe_n}: write 001, read 010, idle 111, read with oe high 011
  // entry: ctlA,addrA,dataA, ctlB,addrB,dataB, stallA_n,stallB_n, vA,qA, vB,qB
  localparam int NV = 22;
  localparam logic [61:0] VEC [NV] = '{
    {3'b001,8'd10,9'h155, 3'b111,8'd0,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b111,8'd0,9'h000,  3'b001,8'd20,9'h0AA, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b010,8'd10,9'h000, 3'b010,8'd20,9'h000, 1'b1,1'b1, 1'b1,9'h155, 1'b1,9'h0AA},
    {3'b001,8'd30,9'h001, 3'b001,8'd31,9'h1FE, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b010,8'd31,9'h000, 3'b010,8'd30,9'h000, 1'b1,1'b1, 1'b1,9'h1FE, 1'b1,9'h001},
    {3'b001,8'd40,9'h0F0, 3'b111,8'd0,9'h000,  1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b010,8'd40,9'h000, 3'b111,8'd0,9'h000,  1'b1,1'b1, 1'b1,9'h0F0, 1'b0,9'h000},
    {3'b010,8'd40,9'h000, 3'b001,8'd40,9'h111, 1'b1,1'b0, 1'b1,9'h0F0, 1'b0,9'h000},
    {3'b010,8'd40,9'h000, 3'b001,8'd40,9'h111, 1'b1,1'b0, 1'b1,9'h0F0, 1'b0,9'h000},
    {3'b010,8'd40,9'h000, 3'b010,8'd40,9'h000, 1'b1,1'b0, 1'b1,9'h0F0, 1'b1,9'h0F0},
    {3'b111,8'd40,9'h000, 3'b001,8'd40,9'h111, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b010,8'd40,9'h000, 3'b111,8'd0,9'h000,  1'b1,1'b1, 1'b1,9'h111, 1'b0,9'h000},
    {3'b111,8'd0,9'h000,  3'b111,8'd0,9'h000,  1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b001,8'd50,9'h0C3, 3'b001,8'd50,9'h13C, 1'b1,1'b0, 1'b0,9'h000, 1'b0,9'h000},
    {3'b111,8'd0,9'h000,  3'b010,8'd50,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b1,9'h0C3},
    {3'b111,8'd0,9'h000,  3'b001,8'd60,9'h0AB, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000},
    {3'b001,8'd61,9'h1AA, 3'b010,8'd60,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b1,9'h0AB},
    {3'b010,8'd60,9'h000, 3'b010,8'd60,9'h000, 1'b0,1'b1, 1'b1,9'h0AB, 1'b1,9'h0AB},
    {3'b001,8'd60,9'h077, 3'b010,8'd60,9'h000, 1'b0,1'b1, 1'b0,9'h000, 1'b1,9'h0AB},
    {3'b001,8'd60,9'h077, 3'b010,8'd61,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b1,9'h1AA},
    {3'b111,8'd0,9'h000,  3'b010,8'd60,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b1,9'h077},
    {3'b011,8'd60,9'h000, 3'b011,8'd61,9'h000, 1'b1,1'b1, 1'b0,9'h000, 1'b0,9'h000}
  };

  function automatic string vec_tag(int k);
    case (k)
      0, 1, 3:          return "R3";
      2, 4:             return "R1";
      5, 6, 15, 16:     return "R3";
      7, 8:             return "R6";
      9:                return "R9";
      10, 11, 19, 20:   return "R7";
      12:               return "R2";
      13, 14:           return "R8";
      17, 18:           return "R5";
      default:          return "R4";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] ca, logic [7:0] aa, logic [8:0] da,
                       logic [2:0] cb, logic [7:0] ab, logic [8:0] db);
    @(negedge clk);
    {a_cs_n, a_we_n, a_oe_n} = ca; a_addr = aa; a_wdata = da;
    {b_cs_n, b_we_n, b_oe_n} = cb; b_addr = ab; b_wdata = db;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    {a_cs_n, a_we_n, a_oe_n} = 3'b111; a_addr = '0; a_wdata = '0;
    {b_cs_n, b_we_n, b_oe_n} = 3'b111; b_addr = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "a_rvalid", {8'd0, a_rvalid}, 9'd0);
    chk("R10", "b_rvalid", {8'd0, b_rvalid}, 9'd0);
    chk("R10", "stall flags", {7'd0, a_stall_n, b_stall_n}, 9'd3);
    @(negedge clk) rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [61:0] v;
      v = VEC[k];
      drive(v[61:59], v[58:51], v[50:42], v[41:39], v[38:31], v[30:22]);
      chk(vec_tag(k), "a_stall_n", {8'd0, a_stall_n}, {8'd0, v[21]});
      chk(vec_tag(k), "b_stall_n", {8'd0, b_stall_n}, {8'd0, v[20]});
      chk(vec_tag(k), "a_rvalid",  {8'd0, a_rvalid},  {8'd0, v[19]});
      if (v[19]) chk(vec_tag(k), "a_rdata", a_rdata, v[18:10]);
      chk(vec_tag(k), "b_rvalid",  {8'd0, b_rvalid},  {8'd0, v[9]});
      if (v[9])  chk(vec_tag(k), "b_rdata", b_rdata, v[8:0]);
    end

    // R2: write strobe low with select high leaves word 10 untouched
    drive(3'b101, 8'd10, 9'h000, 3'b111, 8'd0, 9'h000);
    chk("R2", "a_rvalid deselected", {8'd0, a_rvalid}, 9'd0);
    drive(3'b010, 8'd10, 9'h000, 3'b111, 8'd0, 9'h000);
    chk("R2", "word 10 after deselected write", a_rdata, 9'h155);

    // R1: top address reachable from both sides
    drive(3'b001, 8'd255, 9'h1C7, 3'b111, 8'd0, 9'h000);
    drive(3'b111, 8'd0, 9'h000, 3'b010, 8'd255, 9'h000);
    chk("R1", "b_rdata word 255", b_rdata, 9'h1C7);

    // R10: reset during a B-first collision; afterwards resolved as a tie
    drive(3'b111, 8'd0, 9'h000, 3'b010, 8'd70, 9'h000);
    drive(3'b010, 8'd70, 9'h000, 3'b010, 8'd70, 9'h000);
    chk("R5", "a_stall_n B first", {8'd0, a_stall_n}, 9'd0);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R10", "a_stall_n after reset", {8'd0, a_stall_n}, 9'd1);
    chk("R10", "b_stall_n after reset", {8'd0, b_stall_n}, 9'd0);

    finish_run();
  end
endmodule